// File: doc/BRIEF.md
# Gated Up/Down Pulse Counter Array

This block sits behind eight digital input pins and turns some of them into pulse counters. A mode input picks one of three pin plans. The first plan, which is the reset default, has two counters and leaves two pins as plain inputs. The second has one counter and five plain inputs. The third has no counter, so all eight pins are plain inputs. Each counter uses three pins: a count clock, an up/down direction and a gate. It counts rising edges of its clock pin after those edges pass through a synchroniser.

A host writes a control word for each channel. The word holds a set-counter request, an inhibit request and a 32-bit preset value. The host reads back the count, a status nibble and two input words. The status nibble confirms that each request has been taken over and shows the live levels of the counter's pins. One input word carries every pin level. The other carries only the pins that no active counter owns. A counter is disabled when its registered inhibit bit differs from the level on its gate pin. Two supply short flags from outside are passed through to the host unchanged.

Top module: `pulse_count_front`

## Requirements
- R1: After reset, every count, status nibble, input word and error flag is zero.
- R2: Mode 0 makes channels 0 and 1 active, mode 1 makes only channel 0 active, and modes 2 and 3 make no channel active. An inactive channel ignores clock pulses and set requests, and its done and inhibited status bits stay 0.
- R3: When the set request of an active channel rises, the channel loads its preset value into the count on the next clock. Status bit 0 (done) is the set request one cycle later. If a counted edge arrives in the same cycle as the load, the load wins.
- R4: Status bit 1 (inhibited) is the inhibit request of an active channel, one cycle later.
- R5: A counter is disabled while its inhibited bit XOR its synchronised gate pin is 1. A disabled counter holds its value.
- R6: An enabled counter steps once for each synchronised rising edge of its clock pin. It counts up when the up/down pin is high and down when it is low, and it wraps modulo 2^32.
- R7: Status bit 2 shows the synchronised up/down pin level and status bit 3 shows the synchronised clock pin level, in every mode.
- R8: Channel c uses pin 3c as clock, pin 3c+1 as up/down and pin 3c+2 as gate. The plain input word equals the pin levels with the pins of the active channels forced to 0.
- R9: The raw input word shows all eight pin levels in every mode. The low and high error flags follow their short inputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Pin plan: 0 two counters, 1 one counter, 2 or 3 plain inputs only |
| pins | input | 8 | Asynchronous digital input pins |
| short_lo | input | 1 | External flag: supply short on inputs 0 to 3 |
| short_hi | input | 1 | External flag: supply short on inputs 4 to 7 |
| ctrl_set | input | 2 | Set-counter request, one bit per channel |
| ctrl_inh | input | 2 | Inhibit request, one bit per channel |
| set_val | input | 2x32 | Preset value for each channel |
| count | output | 2x32 | Count value of each channel |
| stat | output | 2x4 | Status per channel: bit 0 done, bit 1 inhibited, bit 2 up/down level, bit 3 clock level |
| raw_in | output | 8 | Synchronised levels of all pins |
| plain_in | output | 8 | Pin levels with the pins of active counters masked to 0 |
| err_lo | output | 1 | Registered short flag for inputs 0 to 3 |
| err_hi | output | 1 | Registered short flag for inputs 4 to 7 |

## Verification
The assertions check the counter on every cycle. A count can change by at most one step unless a load is under way. A disabled or inactive counter holds its value. The done and inhibited bits echo their requests, and an inactive channel keeps both at 0. The bench sweeps every mode against every combination of direction, gate and inhibit, with loads and pulse trains. This sweep shows what the assertions cannot: the exact count the XOR enable rule yields, the pin masking for each mode, the wrap at both ends, and the load winning over a counted edge in the same cycle.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  localparam int MODE_W  = 2;
  localparam int CH_PINS = 3;
  localparam int STAT_W  = 4;
  // status nibble bit positions
  localparam int ST_DONE = 0;
  localparam int ST_INH  = 1;
  localparam int ST_UD   = 2;
  localparam int ST_CLK  = 3;
  // pin offsets inside a channel's pin group
  localparam int PO_CLK  = 0;
  localparam int PO_UD   = 1;
  localparam int PO_GATE = 2;
endpackage

// File: rtl/pcf_pin_sync.sv
module pcf_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[k] <= '0;
        else     chain[k] <= chain[k-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pcf_mode_map.sv
module pcf_mode_map
  import pcf_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int NUM_CH = 2
) (
  input  logic [MODE_W-1:0] mode,
  output logic [NUM_CH-1:0] ch_act,
  output logic [PINS-1:0]   pin_mask
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_act
      // a higher mode number retires channels from the top down
      assign ch_act[c] = (c + int'(mode)) < NUM_CH;
    end
    for (genvar p = 0; p < PINS; p++) begin : g_mask
      if (p / CH_PINS < NUM_CH) begin : g_owned
        assign pin_mask[p] = ch_act[p / CH_PINS];
      end else begin : g_free
        assign pin_mask[p] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/pcf_count_channel.sv
module pcf_count_channel
  import pcf_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              clk_lvl,
  input  logic              ud_lvl,
  input  logic              gate_lvl,
  input  logic              set_req,
  input  logic              inh_req,
  input  logic [CNT_W-1:0]  set_val,
  output logic [CNT_W-1:0]  count,
  output logic [STAT_W-1:0] stat
);
  logic clk_prev, set_done, inh_q, ud_q, clk_q;
  logic rise, load, enabled;

  assign rise    = clk_lvl & ~clk_prev;
  assign load    = act & set_req & ~set_done;
  assign enabled = act & ~(inh_q ^ gate_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev <= 1'b0;
      set_done <= 1'b0;
      inh_q    <= 1'b0;
      ud_q     <= 1'b0;
      clk_q    <= 1'b0;
      count    <= '0;
    end else begin
      clk_prev <= clk_lvl;
      set_done <= act & set_req;
      inh_q    <= act & inh_req;
      ud_q     <= ud_lvl;
      clk_q    <= clk_lvl;
      if (load)
        count <= set_val;
      else if (enabled && rise)
        count <= ud_lvl ? count + CNT_W'(1) : count - CNT_W'(1);
    end
  end

  always_comb begin
    stat          = '0;
    stat[ST_DONE] = set_done;
    stat[ST_INH]  = inh_q;
    stat[ST_UD]   = ud_q;
    stat[ST_CLK]  = clk_q;
  end

  // R3: a taken load shows the preset on the next cycle
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (act && set_req && !set_done) |=> (count == $past(set_val)));

  // R3: done drops once the request is released
  p_done_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !set_req |=> !set_done);

  // R4: inhibit request is echoed
  p_inh_echo_r4: assert property (@(posedge clk) disable iff (rst)
    (act && inh_req) |=> inh_q);

  // R5: a disabled or inactive counter holds
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ((!act || (inh_q ^ gate_lvl)) && !(act && set_req && !set_done)) |=> $stable(count));

  // R6: outside a load the count moves by at most one step
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    !(act && set_req && !set_done) |=>
      (count == $past(count) || count == $past(count) + CNT_W'(1) ||
       count == $past(count) - CNT_W'(1)));

  // R2: inactive channel reports no taken requests
  p_inactive_r2: assert property (@(posedge clk) disable iff (rst)
    !act |=> (!set_done && !inh_q));
endmodule

// File: rtl/pulse_count_front.sv
module pulse_count_front
  import pcf_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [MODE_W-1:0]             mode,
  input  logic [PINS-1:0]               pins,
  input  logic                          short_lo,
  input  logic                          short_hi,
  input  logic [NUM_CH-1:0]             ctrl_set,
  input  logic [NUM_CH-1:0]             ctrl_inh,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  set_val,
  output logic [NUM_CH-1:0][CNT_W-1:0]  count,
  output logic [NUM_CH-1:0][STAT_W-1:0] stat,
  output logic [PINS-1:0]               raw_in,
  output logic [PINS-1:0]               plain_in,
  output logic                          err_lo,
  output logic                          err_hi
);
  localparam int USED_PINS = NUM_CH * CH_PINS;

  logic [PINS-1:0]   pin_s;
  logic [NUM_CH-1:0] ch_act;
  logic [PINS-1:0]   pin_mask;

  pcf_pin_sync #(.W(PINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .din(pins), .dout(pin_s)
  );

  pcf_mode_map #(.PINS(PINS), .NUM_CH(NUM_CH)) u_map (
    .mode(mode), .ch_act(ch_act), .pin_mask(pin_mask)
  );

  generate
    if (USED_PINS > PINS) begin : g_bad_cfg
      initial $error("pin plan needs more pins than PINS");
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pcf_count_channel #(.CNT_W(CNT_W)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .act     (ch_act[c]),
        .clk_lvl (pin_s[c*CH_PINS + PO_CLK]),
        .ud_lvl  (pin_s[c*CH_PINS + PO_UD]),
        .gate_lvl(pin_s[c*CH_PINS + PO_GATE]),
        .set_req (ctrl_set[c]),
        .inh_req (ctrl_inh[c]),
        .set_val (set_val[c]),
        .count   (count[c]),
        .stat    (stat[c])
      );
    end
  endgenerate

  assign raw_in = pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      plain_in <= '0;
      err_lo   <= 1'b0;
      err_hi   <= 1'b0;
    end else begin
      plain_in <= pin_s & ~pin_mask;
      err_lo   <= short_lo;
      err_hi   <= short_hi;
    end
  end
endmodule

// File: tb/test_pulse_count_front.sv
module test_pulse_count_front;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] mode;
  logic [7:0] pins;
  logic short_lo, short_hi;
  logic [1:0] ctrl_set, ctrl_inh;
  logic [1:0][31:0] set_val;
  logic [1:0][31:0] count;
  logic [1:0][3:0] stat;
  logic [7:0] raw_in, plain_in;
  logic err_lo, err_hi;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] exp_cnt [2];

  always #5 clk = ~clk;

  pulse_count_front i_pulse_count_front (
    .clk(clk), .rst(rst), .mode(mode), .pins(pins),
    .short_lo(short_lo), .short_hi(short_hi),
    .ctrl_set(ctrl_set), .ctrl_inh(ctrl_inh), .set_val(set_val),
    .count(count), .stat(stat), .raw_in(raw_in), .plain_in(plain_in),
    .err_lo(err_lo), .err_hi(err_hi)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_act(int ch, logic [1:0] m);
    return (ch + int'(m)) < 2;
  endfunction

  function automatic logic [7:0] mask_of(logic [1:0] m);
    logic [7:0] r = '0;
    for (int p = 0; p < 6; p++) if (is_act(p / 3, m)) r[p] = 1'b1;
    return r;
  endfunction

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(logic [31:0] v0, logic [31:0] v1);
    set_val[0] = v0;
    set_val[1] = v1;
    ctrl_set = 2'b11;
    settle(2);
    for (int c = 0; c < 2; c++) begin
      if (is_act(c, mode)) exp_cnt[c] = set_val[c];
      chk("R3 done set", 32'(stat[c][0]), 32'(is_act(c, mode)));
      chk("R3 load value", count[c], exp_cnt[c]);
    end
    ctrl_set = 2'b00;
    settle(2);
    for (int c = 0; c < 2; c++)
      chk("R3 done clear", 32'(stat[c][0]), 32'd0);
  endtask

  task automatic pulses(int n);
    for (int k = 0; k < n; k++) begin
      pins[0] = 1'b1; pins[3] = 1'b1;
      settle(3);
      pins[0] = 1'b0; pins[3] = 1'b0;
      settle(3);
      for (int c = 0; c < 2; c++)
        if (is_act(c, mode) && !(ctrl_inh[c] ^ pins[c*3+2]))
          exp_cnt[c] = pins[c*3+1] ? exp_cnt[c] + 32'd1 : exp_cnt[c] - 32'd1;
    end
  endtask

  initial begin
    rst = 1'b1; mode = 2'd0; pins = '0; short_lo = 0; short_hi = 0;
    ctrl_set = 0; ctrl_inh = 0; set_val = '0;
    exp_cnt[0] = 0; exp_cnt[1] = 0;
    settle(3);
    rst = 1'b0;
    settle(1);
    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      chk("R1 count", count[c], 32'd0);
      chk("R1 stat", 32'(stat[c]), 32'd0);
    end
    chk("R1 plain", 32'(plain_in), 32'd0);
    chk("R1 raw", 32'(raw_in), 32'd0);
    chk("R1 err", 32'({err_lo, err_hi}), 32'd0);

    // R2 R4 R5 R6 R7 R8 sweep: mode x direction x gate x inhibit
    for (int m = 0; m < 4; m++)
      for (int u = 0; u < 2; u++)
        for (int g = 0; g < 2; g++)
          for (int i = 0; i < 2; i++) begin
            mode = 2'(m);
            pins = {2'(m), 6'b0};
            pins[1] = 1'(u); pins[4] = 1'(u);
            pins[2] = 1'(g); pins[5] = 1'(g);
            ctrl_inh = {1'(i), 1'(i)};
            settle(5);
            do_load(32'd1000 + 32'(m*8 + u*4 + g*2 + i), 32'd5000 + 32'(m));
            pulses(3);
            for (int c = 0; c < 2; c++) begin
              chk("R5 R6 count after pulses", count[c], exp_cnt[c]);
              chk("R4 R2 inhibited echo", 32'(stat[c][1]), 32'(is_act(c, mode) && i == 1));
              chk("R7 ud level", 32'(stat[c][2]), 32'(u));
            end
            chk("R8 plain inputs", 32'(plain_in), 32'(pins & ~mask_of(mode)));
            chk("R9 raw inputs", 32'(raw_in), 32'(pins));
          end

    // R6 wrap at both ends, mode 0, enabled
    mode = 2'd0; ctrl_inh = 0; pins = 8'b0001_0010;  // both ud high, gates low
    settle(5);
    do_load(32'hFFFF_FFFF, 32'hFFFF_FFFE);
    pulses(2);
    chk("R6 wrap up ch0", count[0], 32'd1);
    chk("R6 wrap up ch1", count[1], 32'd0);
    pins = 8'b0;
    settle(5);
    do_load(32'd0, 32'd1);
    pulses(2);
    chk("R6 wrap down ch0", count[0], 32'hFFFF_FFFE);
    chk("R6 wrap down ch1", count[1], 32'hFFFF_FFFF);

    // R3 load wins over an edge in the same cycle
    pins = 8'b0000_0010;
    settle(5);
    set_val[0] = 32'd77;
    pins[0] = 1'b1;
    settle(2);
    ctrl_set[0] = 1'b1;
    settle(1);
    chk("R3 load priority", count[0], 32'd77);
    settle(3);
    chk("R7 clock level", 32'(stat[0][3]), 32'd1);
    ctrl_set = 0; pins[0] = 1'b0;
    settle(4);
    chk("R3 no extra count", count[0], 32'd77);
    chk("R7 clock level low", 32'(stat[0][3]), 32'd0);

    // R9 error flags, all four patterns
    for (int e = 0; e < 4; e++) begin
      short_lo = e[0]; short_hi = e[1];
      settle(2);
      chk("R9 error flags", 32'({err_hi, err_lo}), 32'(e));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule